// File: doc/BRIEF.md
# Single-Port RAM Test Sequencer

This block exercises a small synchronous single-port RAM through its test-mode pins. A start pulse launches a fixed run of three accesses. Each access is a dummy event, then a write event, then a read event. The first access goes to the lowest address, the second to a middle address and the third to the highest address. Every access writes a different data word. The block drives the address, the write data, an active-low chip select, an active-low write enable and a clock enable that lets one return-to-zero RAM clock pulse through per event.

The RAM is taken to register its output on the clock edge that closes an event. The word returned by an event is therefore seen on the read-data input during the cycle after it. Each access ends with one quiet gap cycle, and the word returned by the read event is compared during that gap. Whatever the dummy event returns (old contents) and whatever the write event returns (write-through data) is never looked at.

When the run ends the block shows done, a pass flag, and the address and observed word of the first mismatch. These results hold until the next start.

Top module: `ram_test_seq`

## Requirements
- R1: While reset is high and in the cycle after it, chip select and write enable are high (inactive), clock enable is low, and done and pass are low.
- R2: A start pulse sampled while idle or done begins a run. The first event appears in the cycle after the start edge. A start pulse during a run has no effect on the sequence.
- R3: Each access lasts four cycles. In the dummy cycle chip select is low, write enable is high and clock enable is high. In the write cycle chip select, write enable and clock enable are all active. In the read cycle it is the same as the dummy cycle. In the gap cycle chip select is high and clock enable is low.
- R4: The three accesses use these addresses, in order: all zeros, then the alternating pattern with ones at even bit positions (0101 for 4 bits), then all ones.
- R5: The write data of the three accesses is, in order: all zeros, the alternating pattern with ones at even bit positions, and all ones. Address and data stay unchanged from the dummy cycle through the gap cycle of an access.
- R6: Read data is compared only in the gap cycle, against the data written in the same access. The values returned during the dummy and write events never affect the result.
- R7: The cycle after the third gap, done goes high with chip select inactive. Pass is high only if all three comparisons matched. Both hold until the next start.
- R8: The first mismatch captures its address and observed read word. Later mismatches do not overwrite them. The run still completes all three accesses. If the run passes, both captured values read zero.
- R9: A new start clears pass and the captured values, from the first dummy cycle of the new run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse |
| ram_rdata_i | input | DATA_W | Registered RAM output word |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_wdata_o | output | DATA_W | RAM write data |
| ram_cs_n_o | output | 1 | Chip select, active low |
| ram_we_n_o | output | 1 | Write enable, active low |
| ram_clk_en_o | output | 1 | Enables one RAM clock pulse for the current event |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | All three read comparisons matched |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_data_o | output | DATA_W | Word observed at the first mismatch |

## Verification
The assertions look only at the control and address outputs. They assume that reset is asserted from time zero for at least one edge, and that the start input is the only thing that moves the sequence. The bench holds reset for several cycles and drives start only at falling edges. It also drives start pulses in the middle of a run to show that they are ignored. The RAM model in the bench returns whatever its fault masks and noise mode dictate. The assertions make no assumption about read data, so every fault sweep stays within them.

// File: rtl/rts_pkg.sv
package rts_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DUMMY = 3'd1,
        ST_WRITE = 3'd2,
        ST_READ  = 3'd3,
        ST_GAP   = 3'd4,
        ST_DONE  = 3'd5
    } rts_state_e;

    localparam int unsigned NUM_ACCESS = 3;
    localparam int unsigned ACC_W      = 2;

    typedef struct packed {
        rts_state_e        state;
        logic [ACC_W-1:0]  acc;
    } rts_seq_t;

endpackage

// File: rtl/rts_pattern.sv
module rts_pattern #(
    parameter int unsigned W = 4
) (
    input  logic [rts_pkg::ACC_W-1:0] sel_i,
    output logic [W-1:0]              value_o
);
    logic [W-1:0] alt;

    for (genvar i = 0; i < W; i++) begin : g_alt
        assign alt[i] = ((i % 2) == 0);
    end

    always_comb begin
        case (sel_i)
            2'd0:    value_o = '0;
            2'd1:    value_o = alt;
            default: value_o = '1;
        endcase
    end
endmodule

// File: rtl/rts_fsm.sv
module rts_fsm
    import rts_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output rts_state_e       state_o,
    output logic [ACC_W-1:0] acc_o,
    output logic             launch_o
);
    localparam logic [ACC_W-1:0] LAST_ACC = ACC_W'(NUM_ACCESS - 1);

    rts_seq_t seq_d, seq_q;
    logic     launch;

    always_comb begin
        seq_d  = seq_q;
        launch = 1'b0;
        case (seq_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    seq_d.state = ST_DUMMY;
                    seq_d.acc   = '0;
                    launch      = 1'b1;
                end
            end
            ST_DUMMY: seq_d.state = ST_WRITE;
            ST_WRITE: seq_d.state = ST_READ;
            ST_READ:  seq_d.state = ST_GAP;
            ST_GAP: begin
                if (seq_q.acc == LAST_ACC) begin
                    seq_d.state = ST_DONE;
                end else begin
                    seq_d.state = ST_DUMMY;
                    seq_d.acc   = seq_q.acc + 1'b1;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{state: ST_IDLE, acc: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o  = seq_q.state;
    assign acc_o    = seq_q.acc;
    assign launch_o = launch;
endmodule

// File: rtl/rts_result.sv
module rts_result #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] expect_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              fail_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_data_o
);
    typedef struct packed {
        logic              fail;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (clear_i) begin
            res_d = '0;
        end else if (sample_i && (rdata_i != expect_i) && !res_q.fail) begin
            res_d.fail = 1'b1;
            res_d.addr = addr_i;
            res_d.data = rdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign fail_o      = res_q.fail;
    assign fail_addr_o = res_q.addr;
    assign fail_data_o = res_q.data;
endmodule

// File: rtl/ram_test_seq.sv
module ram_test_seq #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] ram_rdata_i,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    output logic              ram_cs_n_o,
    output logic              ram_we_n_o,
    output logic              ram_clk_en_o,
    output logic              done_o,
    output logic              pass_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_data_o
);
    import rts_pkg::*;

    rts_state_e       state;
    logic [ACC_W-1:0] acc;
    logic             launch;
    logic             fail;
    logic             active;

    rts_fsm i_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .state_o  (state),
        .acc_o    (acc),
        .launch_o (launch)
    );

    rts_pattern #(.W(ADDR_W)) i_addr_pat (
        .sel_i   (acc),
        .value_o (ram_addr_o)
    );

    rts_pattern #(.W(DATA_W)) i_data_pat (
        .sel_i   (acc),
        .value_o (ram_wdata_o)
    );

    rts_result #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_result (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (launch),
        .sample_i    (state == ST_GAP),
        .addr_i      (ram_addr_o),
        .expect_i    (ram_wdata_o),
        .rdata_i     (ram_rdata_i),
        .fail_o      (fail),
        .fail_addr_o (fail_addr_o),
        .fail_data_o (fail_data_o)
    );

    always_comb begin
        active = (state == ST_DUMMY) || (state == ST_WRITE) || (state == ST_READ);
    end

    assign ram_cs_n_o   = !active;
    assign ram_we_n_o   = (state != ST_WRITE);
    assign ram_clk_en_o = active;
    assign done_o       = (state == ST_DONE);
    assign pass_o       = (state == ST_DONE) && !fail;
endmodule

// File: rtl/rts_checker.sv
module rts_checker #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] ram_addr_o,
    input logic [DATA_W-1:0] ram_wdata_o,
    input logic              ram_cs_n_o,
    input logic              ram_we_n_o,
    input logic              ram_clk_en_o,
    input logic              done_o,
    input logic              pass_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (ram_cs_n_o && ram_we_n_o && !ram_clk_en_o && !done_o && !pass_o));

    // R3
    write_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n_o |-> (!ram_cs_n_o && ram_clk_en_o));

    // R3
    write_then_read_chk: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n_o |=> (!ram_cs_n_o && ram_we_n_o && ram_clk_en_o));

    // R5
    hold_from_dummy_chk: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n_o |-> ($stable(ram_addr_o) && $stable(ram_wdata_o)));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (ram_cs_n_o && !ram_clk_en_o && ram_we_n_o));

    // R7
    pass_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> done_o);
endmodule

bind ram_test_seq rts_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rts_checker (
    .clk          (clk),
    .rst          (rst),
    .ram_addr_o   (ram_addr_o),
    .ram_wdata_o  (ram_wdata_o),
    .ram_cs_n_o   (ram_cs_n_o),
    .ram_we_n_o   (ram_we_n_o),
    .ram_clk_en_o (ram_clk_en_o),
    .done_o       (done_o),
    .pass_o       (pass_o)
);

// File: tb/test_ram_test_seq.sv
`timescale 1ns/1ps
module test_ram_test_seq;
    localparam int AW = 4;
    localparam int DW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [DW-1:0] rdata = '0;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          cs_n, we_n, clk_en, done, pass;
    logic [AW-1:0] faddr;
    logic [DW-1:0] fdata;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [DW-1:0] mem   [DEPTH];
    logic [DW-1:0] fault [DEPTH];
    bit noisy = 0;
    bit last_write = 0;

    always #5 clk = ~clk;

    ram_test_seq #(.ADDR_W(AW), .DATA_W(DW)) i_ram_test_seq (
        .clk(clk), .rst(rst), .start_i(start), .ram_rdata_i(rdata),
        .ram_addr_o(addr), .ram_wdata_o(wdata), .ram_cs_n_o(cs_n),
        .ram_we_n_o(we_n), .ram_clk_en_o(clk_en), .done_o(done),
        .pass_o(pass), .fail_addr_o(faddr), .fail_data_o(fdata)
    );

    // Registered single-port RAM model with per-address read fault masks
    always @(posedge clk) begin
        if (!cs_n && clk_en) begin
            if (!we_n) begin
                mem[addr]  <= wdata;
                rdata      <= noisy ? ~wdata : wdata;
                last_write <= 1'b1;
            end else begin
                rdata      <= (noisy && !last_write) ? ~(mem[addr] ^ fault[addr])
                                                     : (mem[addr] ^ fault[addr]);
                last_write <= 1'b0;
            end
        end
    end

    function automatic logic [AW-1:0] pat_a(int k);
        logic [AW-1:0] v = '0;
        if (k == 0) return '0;
        if (k == 2) return '1;
        for (int i = 0; i < AW; i += 2) v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [DW-1:0] pat_d(int k);
        logic [DW-1:0] v = '0;
        if (k == 0) return '0;
        if (k == 2) return '1;
        for (int i = 0; i < DW; i += 2) v[i] = 1'b1;
        return v;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic prep();
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]   = DW'(i ^ 10);
            fault[i] = '0;
        end
        noisy = 0;
    endtask

    // One full run; optional extra start pulse in the middle
    task automatic run(bit exp_pass, logic [AW-1:0] ea, logic [DW-1:0] ed, bit mid_start);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 12; k++) begin
            int acc = k / 4;
            int ph  = k % 4;
            bit e_cs_n = (ph == 3);
            bit e_we_n = (ph != 1);
            bit e_en   = (ph != 3);
            check(cs_n == e_cs_n && we_n == e_we_n && clk_en == e_en && !done,
                  "R3", "controls", {cs_n, we_n, clk_en, done}, {e_cs_n, e_we_n, e_en, 1'b0});
            check(addr == pat_a(acc), "R4", "address", addr, pat_a(acc));
            check(wdata == pat_d(acc), "R5", "write data", wdata, pat_d(acc));
            if (k == 0)
                check(faddr == 0 && fdata == 0 && !pass, "R9", "cleared result",
                      {faddr, fdata}, 0);
            start = (mid_start && k == 5);
            @(negedge clk);
        end
        start = 1'b0;
        check(done && cs_n && !clk_en, "R7", "done state", {done, cs_n, clk_en}, 3'b110);
        check(pass == exp_pass, "R6", "pass flag", pass, exp_pass);
        check(faddr == (exp_pass ? '0 : ea), "R8", "fail address", faddr, exp_pass ? 0 : ea);
        check(fdata == (exp_pass ? '0 : ed), "R8", "fail data", fdata, exp_pass ? 0 : ed);
        repeat (3) @(negedge clk);
        check(done && pass == exp_pass, "R7", "result held", {done, pass}, {1'b1, exp_pass});
    endtask

    initial begin
        prep();
        repeat (4) @(negedge clk);
        check(cs_n && we_n && !clk_en && !done && !pass, "R1", "reset outputs",
              {cs_n, we_n, clk_en, done, pass}, 5'b11000);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n && we_n && !clk_en && !done, "R1", "idle after reset",
              {cs_n, we_n, clk_en, done}, 4'b1100);

        // R2: clean RAM run
        prep(); run(1, '0, '0, 0);
        // R2: start during a run ignored
        prep(); run(1, '0, '0, 1);
        // R6: noisy dummy and write returns ignored
        prep(); noisy = 1; run(1, '0, '0, 0);
        // R8: first mismatch kept when several accesses fail
        prep(); fault[pat_a(1)] = 4'b0010; fault[pat_a(2)] = 4'b1000;
        run(0, pat_a(1), pat_d(1) ^ 4'b0010, 0);
        // R9: rerun on a clean RAM after a failure
        prep(); run(1, '0, '0, 0);
        // fault at an unvisited address has no effect
        prep(); fault[3] = '1; run(1, '0, '0, 0);
        // Sweep: every single-bit fault at each visited address
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < DW; b++) begin
                prep();
                fault[pat_a(a)] = DW'(1 << b);
                run(0, pat_a(a), pat_d(a) ^ DW'(1 << b), 0);
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule